// File: doc/BRIEF.md
# Infrared Mark/Space Burst Sequencer

This block turns a queue of timed intervals into an infrared burst. Software pushes 32-bit words through a write port. Each accepted word becomes one interval. During that interval the output either carries the modulated carrier (a mark) or is held low (a space). The interval lasts for a count of ticks from a timebase that the word selects. The sequencer plays entries back to back without a gap. When the queue runs dry, the output goes low and the sequencer waits.

A control/status word holds three things: a queue-level threshold, an interrupt enable, and a sticky pending flag. The pending flag is raised when the queue drains down to the threshold, which tells software that it is time to refill. The carrier waveform, the carrier-period strobe and the 1 µs, 10 µs and 100 µs tick enables all come from outside the block.

Top module: `ir_burst_sequencer`

## Requirements
- R1: A write on the push port enters the queue only when bit 16 of the pushed word is 1. A word with bit 16 at 0 is discarded.
- R2: Bit 12 of an entry selects a mark (1) or a space (0). During a mark, `ir_out` follows `carrier_in`. During a space, `ir_out` is 0.
- R3: Bits 11:10 of an entry select the timebase: 0 is `tick_1us`, 1 is `tick_10us`, 2 is `tick_100us`, 3 is `carrier_tick`. Only strobes from the selected source advance the interval.
- R4: Bits 9:0 hold the interval length minus one. An interval ends on its (value+1)-th selected strobe.
- R5: On the strobe that ends an interval, the next queued entry starts in the same clock edge, with no gap.
- R6: While the queue is empty and no interval is running, `ir_out` is 0.
- R7: The queue holds 128 entries. A qualified push to a full queue is dropped and sets the sticky overflow flag (status bit 17). Writing 0 to bit 17 clears the flag; writing 1 leaves it unchanged.
- R8: The pending flag (status bit 16) sets in the same edge at which the occupancy goes from above the threshold (bits 7:0) to at or below it. Writing 0 to bit 16 clears the flag. Writing 1 leaves it unchanged, and a new crossing takes priority over a clear.
- R9: `irq` is 1 exactly when the pending flag and the interrupt enable (bit 8) are both 1.
- R10: After reset, `ir_out` and `irq` are 0 and the control/status word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Write strobe for the push port |
| push_data | input | 32 | Interval word to push |
| ctl_we | input | 1 | Write strobe for the control/status word |
| ctl_wdata | input | 32 | Control/status write data |
| ctl_rdata | output | 32 | Control/status read value |
| carrier_in | input | 1 | Modulated carrier waveform |
| carrier_tick | input | 1 | One-cycle strobe per carrier period |
| tick_1us | input | 1 | 1 µs tick enable |
| tick_10us | input | 1 | 10 µs tick enable |
| tick_100us | input | 1 | 100 µs tick enable |
| ir_out | output | 1 | Infrared drive output |
| irq | output | 1 | Refill interrupt |

## Verification
A wrong interval counter shows up at `ir_out` at the end of the interval: the mark or space ends one or more strobes too early or too late. Counting with the wrong timebase shows up at the first unrelated strobe, because the next entry then starts early. A queue pointer or occupancy error appears only when the queue drains. It shows as a wrong entry being played, a missing entry, or an extra one after the dropped overflow push. It also shifts the cycle at which `irq` rises relative to the number of strobes applied.

// File: rtl/ir_burst_pkg.sv
`timescale 1ns/1ps
package ir_burst_pkg;

  localparam int SLOT_LEN_W = 10;

  typedef enum logic [1:0] {
    TB_1US     = 2'd0,
    TB_10US    = 2'd1,
    TB_100US   = 2'd2,
    TB_CARRIER = 2'd3
  } tbase_e;

  typedef struct packed {
    logic                  mark;
    tbase_e                tb;
    logic [SLOT_LEN_W-1:0] len_m1;
  } slot_t;

  // decode the low 13 bits of a pushed word into a queue slot
  function automatic slot_t unpack_word(input logic [12:0] w);
    slot_t s;
    s.mark   = w[12];
    s.tb     = tbase_e'(w[11:10]);
    s.len_m1 = w[SLOT_LEN_W-1:0];
    return s;
  endfunction

  // strobe of the timebase chosen by the slot
  function automatic logic pick_tick(input tbase_e tb, input logic t1, input logic t10,
                                     input logic t100, input logic tc);
    case (tb)
      TB_1US:   return t1;
      TB_10US:  return t10;
      TB_100US: return t100;
      default:  return tc;
    endcase
  endfunction

  // occupancy moves from above the level to at-or-below it
  function automatic logic drained_to(input logic [15:0] now_lvl, input logic [15:0] next_lvl,
                                      input logic [15:0] thr);
    return (now_lvl > thr) && (next_lvl <= thr);
  endfunction

endpackage

// File: rtl/ir_burst_queue.sv
`timescale 1ns/1ps
module ir_burst_queue
  import ir_burst_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  slot_t         wr_slot,
  input  logic          rd_en,
  output slot_t         rd_slot,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nx,
  output logic          full,
  output logic          empty,
  output logic          drop
);

  slot_t         mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          wr_ok, rd_ok;

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign wr_ok    = wr_en && !full;
  assign rd_ok    = rd_en && !empty;
  assign drop     = wr_en && full;
  assign count_nx = count + CW'(wr_ok) - CW'(rd_ok);
  assign rd_slot  = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_slot;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_ok) wr_ptr <= bump(wr_ptr);
      if (rd_ok) rd_ptr <= bump(rd_ptr);
      count <= count_nx;
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en) |=> (count == $past(count)));

endmodule

// File: rtl/ir_burst_player.sv
`timescale 1ns/1ps
module ir_burst_player
  import ir_burst_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  slot_t head,
  input  logic  empty,
  input  logic  carrier_in,
  input  logic  carrier_tick,
  input  logic  tick_1us,
  input  logic  tick_10us,
  input  logic  tick_100us,
  output logic  pop,
  output logic  ir_out
);

  logic                  active;
  slot_t                 cur;
  logic [SLOT_LEN_W-1:0] remain;
  logic                  sel_tick;
  logic                  finish;

  assign sel_tick = pick_tick(cur.tb, tick_1us, tick_10us, tick_100us, carrier_tick);
  assign finish   = active && sel_tick && (remain == '0);
  assign pop      = !empty && (!active || finish);
  assign ir_out   = active && cur.mark && carrier_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cur    <= '0;
      remain <= '0;
    end else if (pop) begin
      active <= 1'b1;
      cur    <= head;
      remain <= head.len_m1;
    end else if (finish) begin
      active <= 1'b0;
    end else if (active && sel_tick) begin
      remain <= remain - SLOT_LEN_W'(1);
    end
  end

  assert_countdown_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && sel_tick && remain != '0) |=> (remain == $past(remain) - SLOT_LEN_W'(1)));

  assert_pop_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && active) |-> (sel_tick && remain == '0));

  assert_end_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> ($past(remain) == '0));

endmodule

// File: rtl/ir_burst_sequencer.sv
`timescale 1ns/1ps
module ir_burst_sequencer
  import ir_burst_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push_valid,
  input  logic [31:0] push_data,
  input  logic        ctl_we,
  input  logic [31:0] ctl_wdata,
  output logic [31:0] ctl_rdata,
  input  logic        carrier_in,
  input  logic        carrier_tick,
  input  logic        tick_1us,
  input  logic        tick_10us,
  input  logic        tick_100us,
  output logic        ir_out,
  output logic        irq
);

  slot_t         head;
  logic [CW-1:0] count, count_nx;
  logic          full, empty, drop, pop, push_ok;
  logic [CW-1:0] thr;
  logic          irq_en, pend, ovf;
  logic          crossing;
  logic          spare_bits_unused;

  assign push_ok  = push_valid && push_data[16];
  assign crossing = drained_to(16'(count), 16'(count_nx), 16'(thr));
  assign spare_bits_unused = ^{push_data[31:17], push_data[15:13], full,
                               ctl_wdata[31:18], ctl_wdata[15:9], ctl_wdata[7:CW]};

  ir_burst_queue #(.DEPTH(DEPTH)) i_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (push_ok),
    .wr_slot  (unpack_word(push_data[12:0])),
    .rd_en    (pop),
    .rd_slot  (head),
    .count    (count),
    .count_nx (count_nx),
    .full     (full),
    .empty    (empty),
    .drop     (drop)
  );

  ir_burst_player i_player (
    .clk          (clk),
    .rst_n        (rst_n),
    .head         (head),
    .empty        (empty),
    .carrier_in   (carrier_in),
    .carrier_tick (carrier_tick),
    .tick_1us     (tick_1us),
    .tick_10us    (tick_10us),
    .tick_100us   (tick_100us),
    .pop          (pop),
    .ir_out       (ir_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr    <= '0;
      irq_en <= 1'b0;
      pend   <= 1'b0;
      ovf    <= 1'b0;
    end else if (ctl_we) begin
      thr    <= ctl_wdata[CW-1:0];
      irq_en <= ctl_wdata[8];
      pend   <= crossing | (pend & ctl_wdata[16]);
      ovf    <= drop | (ovf & ctl_wdata[17]);
    end else begin
      pend   <= pend | crossing;
      ovf    <= ovf | drop;
    end
  end

  always_comb begin
    ctl_rdata         = '0;
    ctl_rdata[CW-1:0] = thr;
    ctl_rdata[8]      = irq_en;
    ctl_rdata[16]     = pend;
    ctl_rdata[17]     = ovf;
  end

  assign irq = pend & irq_en;

  assert_pend_on_cross_R8: assert property (@(posedge clk) disable iff (!rst_n)
    crossing |=> pend);

  assert_pend_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(crossing));

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ctl_we) |=> ovf);

endmodule

// File: tb/test_ir_burst_sequencer.sv
`timescale 1ns/1ps
module test_ir_burst_sequencer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 1'b0;
  logic [31:0] push_data = '0;
  logic        ctl_we = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] ctl_rdata;
  logic        carrier_in = 1'b0;
  logic        carrier_tick = 1'b0;
  logic        tick_1us = 1'b0;
  logic        tick_10us = 1'b0;
  logic        tick_100us = 1'b0;
  logic        ir_out;
  logic        irq;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  ir_burst_sequencer i_ir_burst_sequencer (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .carrier_in(carrier_in), .carrier_tick(carrier_tick), .tick_1us(tick_1us),
    .tick_10us(tick_10us), .tick_100us(tick_100us), .ir_out(ir_out), .irq(irq)
  );

  function automatic logic [31:0] mkw(input bit mark, input int tb, input int len_m1);
    return 32'h0001_0000 | (32'(mark) << 12) | (32'(tb) << 10) | 32'(len_m1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk); push_valid = 1'b1; push_data = w;
    step(); push_valid = 1'b0;
  endtask

  task automatic ctl_write(input logic [31:0] w);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = w;
    step(); ctl_we = 1'b0;
  endtask

  // sel: 0 1us, 1 10us, 2 100us, 3 carrier period
  task automatic pulse(input int sel);
    @(negedge clk);
    case (sel)
      0: tick_1us = 1'b1;
      1: tick_10us = 1'b1;
      2: tick_100us = 1'b1;
      default: carrier_tick = 1'b1;
    endcase
    step();
    tick_1us = 1'b0; tick_10us = 1'b0; tick_100us = 1'b0; carrier_tick = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    chk("R10 ir_out", 32'(ir_out), 0);
    chk("R10 irq", 32'(irq), 0);
    chk("R10 ctl_rdata", ctl_rdata, 0);
  endtask

  task automatic t_mark_len();
    carrier_in = 1'b1;
    push(mkw(1, 0, 2)); step();
    chk("R2 mark follows carrier high", 32'(ir_out), 1);
    carrier_in = 1'b0; #1;
    chk("R2 mark follows carrier low", 32'(ir_out), 0);
    carrier_in = 1'b1; #1;
    pulse(1);
    chk("R3 foreign tick ignored", 32'(ir_out), 1);
    pulse(0); pulse(0);
    chk("R4 still running after 2 of 3", 32'(ir_out), 1);
    pulse(0);
    chk("R4 ended after 3 ticks", 32'(ir_out), 0);
    step();
    chk("R6 idle low when empty", 32'(ir_out), 0);
  endtask

  task automatic t_space_then_mark();
    push(mkw(0, 1, 1)); push(mkw(1, 0, 0)); step();
    chk("R2 space held low", 32'(ir_out), 0);
    pulse(0); pulse(1);
    chk("R3 space not ended by 1us tick", 32'(ir_out), 0);
    pulse(1);
    chk("R5 next mark starts without gap", 32'(ir_out), 1);
    pulse(0);
    chk("R4 single-tick mark", 32'(ir_out), 0);
  endtask

  task automatic t_carrier_tb();
    push(mkw(1, 3, 1)); step();
    pulse(0); pulse(2);
    chk("R3 carrier timebase ignores us ticks", 32'(ir_out), 1);
    pulse(3);
    chk("R3 carrier timebase one of two", 32'(ir_out), 1);
    pulse(3);
    chk("R3 carrier timebase done", 32'(ir_out), 0);
    push(mkw(1, 2, 0)); step();
    pulse(1);
    chk("R3 100us ignores 10us", 32'(ir_out), 1);
    pulse(2);
    chk("R3 100us done", 32'(ir_out), 0);
  endtask

  task automatic t_unqualified();
    push(mkw(1, 0, 0) & ~32'h0001_0000); step(); step();
    chk("R1 unqualified word not played", 32'(ir_out), 0);
    push(mkw(1, 0, 0)); step();
    chk("R1 qualified word played", 32'(ir_out), 1);
    pulse(0);
    chk("R1 nothing after qualified word", 32'(ir_out), 0);
    pulse(0);
    chk("R1 still nothing", 32'(ir_out), 0);
  endtask

  task automatic t_irq_gate();
    ctl_write(32'h0000_0000);
    push(mkw(0, 0, 0)); step();
    chk("R8 pending set on drain to 0", 32'(ctl_rdata[16]), 1);
    chk("R9 irq masked", 32'(irq), 0);
    ctl_write(32'h0001_0100);
    chk("R9 irq when enabled", 32'(irq), 1);
    chk("R8 writing 1 keeps pending", 32'(ctl_rdata[16]), 1);
    ctl_write(32'h0000_0100);
    chk("R8 cleared by writing 0", 32'(ctl_rdata[16]), 0);
    chk("R9 irq low after clear", 32'(irq), 0);
    pulse(0);
  endtask

  task automatic t_fill_overflow();
    ctl_write(32'h0000_0104);
    @(negedge clk);
    for (int i = 0; i < 130; i++) begin
      push_valid = 1'b1;
      push_data  = (i >= 128) ? mkw(1, 0, 0) : mkw(0, 0, 0);
      if (i == 129) begin
        #1;
        chk("R7 no overflow at 129 pushes", 32'(ctl_rdata[17]), 0);
      end
      @(negedge clk);
    end
    push_valid = 1'b0; #1;
    chk("R7 overflow on push to full", 32'(ctl_rdata[17]), 1);
    step();
    chk("R7 overflow sticky", 32'(ctl_rdata[17]), 1);
    ctl_write(32'h0000_0104);
    chk("R7 overflow cleared", 32'(ctl_rdata[17]), 0);
    for (int k = 0; k < 123; k++) pulse(0);
    chk("R8 no pending above threshold", 32'(irq), 0);
    pulse(0);
    chk("R8 R9 irq at threshold", 32'(irq), 1);
    ctl_write(32'h0000_0104);
    for (int k = 0; k < 4; k++) pulse(0);
    chk("R8 no re-set below threshold", 32'(irq), 0);
    chk("R7 last stored entry plays", 32'(ir_out), 1);
    pulse(0);
    chk("R7 dropped entry not played", 32'(ir_out), 0);
    pulse(0);
    chk("R6 idle after drain", 32'(ir_out), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_mark_len();
    t_space_then_mark();
    t_carrier_tb();
    t_unqualified();
    t_irq_gate();
    t_fill_overflow();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule